// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single clocked register stage placed on the command and address path of a memory module. On every rising clock edge it captures a bank of data inputs together with clock-enable, on-die-termination and chip-select control bits, and drives them out one cycle later. Two static configuration inputs choose how the data bank is laid out. In single-width mode every input bit has one output. In half-width dual mode one half of the input bank is registered and driven out twice, on an A copy and a B copy. A configuration bit picks which half of the inputs feeds the copies.

Two active-low select inputs allow low-power operation. When both are high, the data outputs keep their previous value. The control outputs keep updating whatever the select inputs do. An active-low reset, sampled on the clock edge, clears every register and overrides the select gating.

Top module: `cmd_regbuf`

## Requirements
- R1: Every output reflects the inputs captured at the most recent rising clock edge. An input change between edges does not reach the outputs before the next rising edge.
- R2: When `sel_a_n` and `sel_b_n` are both 1 at a rising edge, `dout` keeps its previous value at that edge.
- R3: When at least one of `sel_a_n` or `sel_b_n` is 0 at a rising edge, `dout` takes its new value at that edge.
- R4: `cke_a`, `odt_a` and `cs_a` register `cke_in`, `odt_in` and `sel_a_n` on every edge, with the select gating ignored.
- R5: When `rst_n` is 0 at a rising edge, every output is 0 after that edge. This holds even when both select inputs are 1.
- R6: With `cfg_dual`=0 and `cfg_back`=0 (single-width mode), `dout[i]` registers `din[i]` for every bit i.
- R7: With `cfg_dual`=1 and `cfg_back`=0 (dual front mode), both `dout[HALF_W-1:0]` and `dout[2*HALF_W-1:HALF_W]` register `din[HALF_W-1:0]`.
- R8: With `cfg_dual`=1 and `cfg_back`=1 (dual back mode), both halves of `dout` register `din[2*HALF_W-1:HALF_W]`.
- R9: In single-width mode, the dual-only outputs `cke_b`, `odt_b` and `cs_b` stay at 0.
- R10: The reserved setting `cfg_dual`=0 with `cfg_back`=1 behaves exactly like single-width mode.
- R11: In either dual mode, `cke_b`, `odt_b` and `cs_b` equal `cke_a`, `odt_a` and `cs_a` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| cfg_dual | input | 1 | Static: 1 selects half-width dual outputs |
| cfg_back | input | 1 | Static: in dual mode, 1 feeds the copies from the upper input half |
| sel_a_n | input | 1 | Active-low select A; also registered onto cs outputs |
| sel_b_n | input | 1 | Active-low select B |
| cke_in | input | 1 | Clock-enable control input |
| odt_in | input | 1 | Termination control input |
| din | input | 2*HALF_W | Data bank input |
| dout | output | 2*HALF_W | Registered data outputs, gated by the selects |
| cke_a | output | 1 | Registered clock-enable |
| cke_b | output | 1 | Dual-mode copy of clock-enable, 0 in single mode |
| odt_a | output | 1 | Registered termination control |
| odt_b | output | 1 | Dual-mode copy of termination control, 0 in single mode |
| cs_a | output | 1 | Registered select A |
| cs_b | output | 1 | Dual-mode copy of select A, 0 in single mode |

## Verification
The assertions assume that `cfg_dual` and `cfg_back` change only while `rst_n` is low, and that reset is held low from time zero for at least one edge. Under that assumption, the check on duplicated halves and the check on dual-only outputs may rely on the mode being fixed since reset. The stimulus changes the configuration only inside a reset window of two clock edges and drives every input on the falling clock edge, so that each input is stable at the capturing edge.

// File: rtl/cmdbuf_pkg.sv
// Shared types for the configurable registered command buffer.
// Assumes the configuration pins are static outside reset.
package cmdbuf_pkg;

    // Output layout chosen by the two configuration pins
    typedef enum logic [1:0] {
        MODE_SINGLE     = 2'd0,
        MODE_DUAL_FRONT = 2'd1,
        MODE_DUAL_BACK  = 2'd2
    } buf_mode_e;

endpackage

// File: rtl/cmdbuf_mode_dec.sv
// Decodes the static configuration pins into an output layout.
// The reserved setting (dual=0, back=1) falls back to single-width mode
// so that every output stays defined.
module cmdbuf_mode_dec
    import cmdbuf_pkg::*;
(
    input  logic      cfg_dual,
    input  logic      cfg_back,
    output buf_mode_e mode
);

    // Purpose: map the pin pair onto a layout, reserved -> single
    always_comb begin
        case ({cfg_dual, cfg_back})
            2'b10:   mode = MODE_DUAL_FRONT;
            2'b11:   mode = MODE_DUAL_BACK;
            default: mode = MODE_SINGLE;
        endcase
    end

endmodule

// File: rtl/cmdbuf_data_stage.sv
// Gated data register bank. The bank captures the mode-dependent next value
// unless both active-low selects are high. Reset is synchronous, active low,
// and overrides the gating. Assumes the mode is static while out of reset.
module cmdbuf_data_stage
    import cmdbuf_pkg::*;
#(
    parameter  int HALF_W = 11,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  buf_mode_e         mode,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data_q
);

    logic [DATA_W-1:0] data_nxt;
    logic              hold;

    assign hold = sel_a_n & sel_b_n;

    // Purpose: build next value per channel for the selected layout
    for (genvar i = 0; i < HALF_W; i++) begin : g_chan
        logic src_bit;
        assign src_bit = (mode == MODE_DUAL_BACK) ? din[HALF_W+i] : din[i];
        assign data_nxt[i]        = (mode == MODE_SINGLE) ? din[i] : src_bit;
        assign data_nxt[HALF_W+i] = (mode == MODE_SINGLE) ? din[HALF_W+i] : src_bit;
    end

    // Purpose: register the bank, freezing it while both selects are high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (!hold) begin
            data_q <= data_nxt;
        end
    end

    AST_HOLD_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_a_n) && $past(sel_b_n)) |-> $stable(data_q)); // R2

    AST_UPDATE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(sel_a_n) && $past(sel_b_n))) |-> (data_q == $past(data_nxt))); // R3

    AST_DATA_RESET: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0)); // R5

endmodule

// File: rtl/cmdbuf_ctrl_stage.sv
// Ungated control registers: clock-enable, termination and chip select.
// These update on every edge regardless of the select gating.
// Reset is synchronous and active low.
module cmdbuf_ctrl_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_in,
    input  logic odt_in,
    input  logic cs_in,
    output logic cke_q,
    output logic odt_q,
    output logic cs_q
);

    // Purpose: capture the control bits on every rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b0;
            odt_q <= 1'b0;
            cs_q  <= 1'b0;
        end else begin
            cke_q <= cke_in;
            odt_q <= odt_in;
            cs_q  <= cs_in;
        end
    end

    AST_CTRL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cke_q == $past(cke_in) && odt_q == $past(odt_in) && cs_q == $past(cs_in))); // R4

    AST_CTRL_RESET: assert property (@(posedge clk)
        !rst_n |=> (!cke_q && !odt_q && !cs_q)); // R5

endmodule

// File: rtl/cmd_regbuf.sv
// Top of the configurable registered command buffer. Ties the mode
// decoder, the gated data bank and the ungated control registers together
// and produces the dual-only B copies of the control outputs.
// Assumes cfg_dual/cfg_back change only while rst_n is low.
module cmd_regbuf
    import cmdbuf_pkg::*;
#(
    parameter  int HALF_W = 11,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic              cfg_back,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              cke_a,
    output logic              cke_b,
    output logic              odt_a,
    output logic              odt_b,
    output logic              cs_a,
    output logic              cs_b
);

    buf_mode_e mode;
    logic      dual_on;
    logic      cke_q, odt_q, cs_q;

    cmdbuf_mode_dec u_dec (
        .cfg_dual (cfg_dual),
        .cfg_back (cfg_back),
        .mode     (mode)
    );

    cmdbuf_data_stage #(.HALF_W(HALF_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .din     (din),
        .data_q  (dout)
    );

    cmdbuf_ctrl_stage u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke_in (cke_in),
        .odt_in (odt_in),
        .cs_in  (sel_a_n),
        .cke_q  (cke_q),
        .odt_q  (odt_q),
        .cs_q   (cs_q)
    );

    // Purpose: B copies exist only in dual layouts, low otherwise
    assign dual_on = (mode != MODE_SINGLE);
    assign cke_a   = cke_q;
    assign odt_a   = odt_q;
    assign cs_a    = cs_q;
    assign cke_b   = dual_on & cke_q;
    assign odt_b   = dual_on & odt_q;
    assign cs_b    = dual_on & cs_q;

    AST_SPARE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dual |-> (!cke_b && !odt_b && !cs_b)); // R9

    AST_DUAL_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dual |-> (dout[DATA_W-1:HALF_W] == dout[HALF_W-1:0])); // R7

    AST_DUAL_CTRL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dual |-> (cke_b == cke_a && odt_b == odt_a && cs_b == cs_a)); // R11

endmodule

// File: tb/cmd_regbuf_bench.sv
// Directed bench for cmd_regbuf: one task per scenario, each self-checking.
module cmd_regbuf_bench;

    localparam int HALF_W = 11;
    localparam int DATA_W = 2 * HALF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_dual = 1'b0;
    logic              cfg_back = 1'b0;
    logic              sel_a_n = 1'b0;
    logic              sel_b_n = 1'b0;
    logic              cke_in = 1'b0;
    logic              odt_in = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cmd_regbuf #(.HALF_W(HALF_W)) u_cmd_regbuf (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_back(cfg_back),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .cke_in(cke_in), .odt_in(odt_in),
        .din(din), .dout(dout), .cke_a(cke_a), .cke_b(cke_b),
        .odt_a(odt_a), .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(input logic [DATA_W-1:0] d, input logic cke, input logic odt,
                         input logic sa, input logic sb);
        din = d; cke_in = cke; odt_in = odt; sel_a_n = sa; sel_b_n = sb;
    endtask

    task automatic configure(input logic dual, input logic back);
        rst_n = 1'b0;
        cfg_dual = dual;
        cfg_back = back;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        configure(1'b0, 1'b0);
        chk("R5 reset dout", 32'(dout), 32'h0);
        chk("R5 reset ctrl", {26'h0, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b}, 32'h0);
    endtask

    task automatic t_single();
        configure(1'b0, 1'b0);
        drive(22'h2A5C3F, 1'b1, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R6 single dout", 32'(dout), 32'h2A5C3F);
        chk("R4 cke/odt/cs_a", {29'h0, cke_a, odt_a, cs_a}, 32'b100);
        chk("R9 spare low", {29'h0, cke_b, odt_b, cs_b}, 32'h0);
        drive(22'h15A3C0, 1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        chk("R1 no change before edge", 32'(dout), 32'h2A5C3F);
        tick();
        chk("R1 new value after edge", 32'(dout), 32'h15A3C0);
        chk("R4 cs follows sel_a_n", {29'h0, cke_a, odt_a, cs_a}, 32'b011);
        chk("R9 spare low with cs_a high", {29'h0, cke_b, odt_b, cs_b}, 32'h0);
    endtask

    task automatic t_gate();
        configure(1'b0, 1'b0);
        drive(22'h000111, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R3 load both low", 32'(dout), 32'h000111);
        drive(22'h3FFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R2 hold both high", 32'(dout), 32'h000111);
        chk("R4 ctrl ungated", {29'h0, cke_a, odt_a, cs_a}, 32'b111);
        drive(22'h0ABCDE, 1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R2 hold second cycle", 32'(dout), 32'h000111);
        chk("R4 ctrl ungated again", {29'h0, cke_a, odt_a, cs_a}, 32'b011);
        drive(22'h123456, 1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R3 update sel_a_n low", 32'(dout), 32'h123456);
        drive(22'h234567, 1'b0, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R3 update sel_b_n low", 32'(dout), 32'h234567);
        drive(22'h0F0F0F, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R3 update both low", 32'(dout), 32'h0F0F0F);
    endtask

    task automatic t_dual_front();
        configure(1'b1, 1'b0);
        drive({11'h5A3, 11'h1C6}, 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R7 front copies", 32'(dout), 32'({11'h1C6, 11'h1C6}));
        chk("R11 ctrl copies", {26'h0, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b}, 32'b111111);
        drive({11'h7FF, 11'h000}, 1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R7 front copies zero", 32'(dout), 32'h0);
        chk("R11 ctrl copies mixed", {26'h0, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b}, 32'b001100);
    endtask

    task automatic t_dual_back();
        configure(1'b1, 1'b1);
        drive({11'h5A3, 11'h1C6}, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R8 back copies", 32'(dout), 32'({11'h5A3, 11'h5A3}));
        drive({11'h0F0, 11'h333}, 1'b1, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R2 dual hold", 32'(dout), 32'({11'h5A3, 11'h5A3}));
        chk("R11 ctrl copies in hold", {26'h0, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b}, 32'b110011);
    endtask

    task automatic t_reserved();
        configure(1'b0, 1'b1);
        drive(22'h3C0F5A, 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R10 reserved as single", 32'(dout), 32'h3C0F5A);
        chk("R10 reserved spare low", {29'h0, cke_b, odt_b, cs_b}, 32'h0);
    endtask

    task automatic t_reset_mid();
        configure(1'b1, 1'b0);
        drive(22'h1FFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R7 loaded before reset", 32'(dout), 32'h3FFFFF);
        drive(22'h2AAAAA, 1'b1, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b0;
        tick();
        chk("R5 reset beats hold dout", 32'(dout), 32'h0);
        chk("R5 reset beats hold ctrl", {26'h0, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b}, 32'h0);
        rst_n = 1'b1;
        drive(22'h000155, 1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R7 resume after reset", 32'(dout), 32'({11'h155, 11'h155}));
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        t_reset_state();
        t_single();
        t_gate();
        t_dual_front();
        t_dual_back();
        t_reserved();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule